// File: doc/BRIEF.md
# Delay-Line Converter Calibration Controller

This controller sits beside a chain of twenty delay stages, each of which narrows a travelling pulse until the pulse dies out. Each stage has a detect bit, and the sampled bits form a thermometer pattern: ones up to the last stage that still saw the pulse, and zeros after it. On every sample strobe the controller turns this pattern into a stage count. A mismatched pattern, where a one follows a zero, is reduced to its run of leading ones and is flagged.

A `start` pulse begins calibration. Two 8-bit bias codes drive an external DAC. One biases the even-numbered stages and the other biases the odd-numbered stages, and a higher code makes the chain faster. The controller first steps the even code upward from zero while the odd code sits at mid-scale. When the count reaches the target of 10, it steps the odd code upward from zero until the count reaches 10 again. The two codes are then frozen, which cancels out per-chip variation. After that, every sample is compared with a golden count, and an anomaly pulse is raised when the two differ by more than a tolerance. If a code reaches full scale without reaching the target, calibration is reported as failed.

Top module: `tdc_cal_ctrl`

## Requirements
- R1: After reset, both bias codes, `count`, `count_valid`, `bubble_err`, `anomaly`, `locked` and `cal_fail` are all 0.
- R2: One cycle after a clock edge with `sample_valid` high, `count` holds the number of consecutive ones in `stage_bits` starting at bit 0 (stage 0 is the first stage), from 0 to 20, and `count_valid` is high for exactly that cycle.
- R3: If a sampled pattern has a 1 at a position above its first 0, `count` is still the run of leading ones and `bubble_err` is 1. `bubble_err` is 0 after a sample with a clean pattern.
- R4: One cycle after `start`, `bias_even` is 0, `bias_odd` is 128 and `cal_fail` is 0. In the even phase, each sample with a count below 10 raises `bias_even` by 1. Neither code changes in a cycle with no sample and no start.
- R5: A sample in the even phase with a count of at least 10 leaves `bias_even` unchanged and sets `bias_odd` to 0. Each later sample with a count below 10 raises `bias_odd` by 1.
- R6: A sample in the odd phase with a count of at least 10 sets `locked` one cycle later. While `locked` is high, both codes stay fixed, including across measurement samples.
- R7: In measurement, a sample whose count differs from `golden` by more than `tol` gives a one-cycle `anomaly` pulse, aligned with the updated `count`. A difference equal to `tol` or smaller gives no pulse.
- R8: A sample below target while the active code is 255 sets `cal_fail`, leaves `locked` low and stops the sweep with the codes unchanged. A new `start` clears `cal_fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin or restart calibration |
| sample_valid | input | 1 | Strobe marking `stage_bits` as a fresh sample |
| stage_bits | input | 20 | Per-stage pulse-detect bits, bit 0 is the first stage |
| golden | input | 5 | Expected count from the golden model |
| tol | input | 5 | Allowed absolute deviation (normally 1) |
| bias_even | output | 8 | Bias code for even-numbered stages |
| bias_odd | output | 8 | Bias code for odd-numbered stages |
| count | output | 5 | Last decoded stage count |
| count_valid | output | 1 | One-cycle pulse when `count` updates |
| bubble_err | output | 1 | Last sample was not a clean thermometer pattern |
| locked | output | 1 | Calibration done, codes frozen |
| cal_fail | output | 1 | A sweep reached full scale without reaching the target |
| anomaly | output | 1 | One-cycle pulse: measured count outside tolerance |

## Verification
Every result comes from a single register stage. `count`, `count_valid`, `bubble_err`, `anomaly`, the code steps and `cal_fail` all change at the clock edge that captures the strobe, and `locked` rises at that same edge once the odd phase hits the target. The bench therefore drives one strobe on a falling edge and reads the ports at the next falling edge, exactly one edge later. A stand-in delay line in the bench maps the present codes to a count, so the expected sweep lengths (192 even steps, then 128 odd steps) follow from the model and not from the design.

// File: rtl/tdc_cal_ctrl.sv
module tdc_cal_ctrl #(
  parameter int NSTAGE = 20,
  parameter int BW     = 8,
  parameter int TARGET = 10,
  localparam int CNTW  = $clog2(NSTAGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sample_valid,
  input  logic [NSTAGE-1:0] stage_bits,
  input  logic [CNTW-1:0]   golden,
  input  logic [CNTW-1:0]   tol,
  output logic [BW-1:0]     bias_even,
  output logic [BW-1:0]     bias_odd,
  output logic [CNTW-1:0]   count,
  output logic              count_valid,
  output logic              bubble_err,
  output logic              locked,
  output logic              cal_fail,
  output logic              anomaly
);
  localparam logic [BW-1:0]   MID  = BW'(1) << (BW - 1);
  localparam logic [BW-1:0]   FULL = '1;
  localparam logic [CNTW-1:0] TGT  = CNTW'(TARGET);

  typedef enum logic [2:0] {S_IDLE, S_EVEN, S_ODD, S_LOCK, S_MEAS} state_t;
  state_t st;

  logic [CNTW-1:0] lead, dev;
  logic            gap, bub;

  always_comb begin
    lead = '0;
    gap  = 1'b0;
    bub  = 1'b0;
    for (int i = 0; i < NSTAGE; i++) begin
      if (!stage_bits[i]) gap = 1'b1;
      else if (gap)       bub = 1'b1;
      else                lead = lead + CNTW'(1);
    end
  end

  assign dev    = (lead >= golden) ? lead - golden : golden - lead;
  assign locked = (st == S_LOCK) || (st == S_MEAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count       <= '0;
      count_valid <= 1'b0;
      bubble_err  <= 1'b0;
      anomaly     <= 1'b0;
    end else begin
      count_valid <= sample_valid;
      anomaly     <= sample_valid && (st == S_MEAS) && (dev > tol);
      if (sample_valid) begin
        count      <= lead;
        bubble_err <= bub;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bias_even <= '0;
      bias_odd  <= '0;
      cal_fail  <= 1'b0;
    end else if (start) begin
      st        <= S_EVEN;
      bias_even <= '0;
      bias_odd  <= MID;
      cal_fail  <= 1'b0;
    end else begin
      case (st)
        S_EVEN: if (sample_valid) begin
          if (lead >= TGT) begin
            st       <= S_ODD;
            bias_odd <= '0;
          end else if (bias_even == FULL) begin
            st       <= S_IDLE;
            cal_fail <= 1'b1;
          end else begin
            bias_even <= bias_even + BW'(1);
          end
        end
        S_ODD: if (sample_valid) begin
          if (lead >= TGT) begin
            st <= S_LOCK;
          end else if (bias_odd == FULL) begin
            st       <= S_IDLE;
            cal_fail <= 1'b1;
          end else begin
            bias_odd <= bias_odd + BW'(1);
          end
        end
        S_LOCK:  st <= S_MEAS;
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/tdc_cal_ctrl_chk.sv
module tdc_cal_ctrl_chk #(
  parameter int NSTAGE = 20,
  parameter int BW     = 8,
  localparam int CNTW  = $clog2(NSTAGE + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            sample_valid,
  input logic [BW-1:0]   bias_even,
  input logic [BW-1:0]   bias_odd,
  input logic [CNTW-1:0] count,
  input logic            count_valid,
  input logic            locked,
  input logic            cal_fail,
  input logic            anomaly
);
  assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(NSTAGE));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> count_valid);

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |=> !count_valid);

  assert_hold_without_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !start) |=> ($stable(bias_even) && $stable(bias_odd)));

  assert_frozen_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !start) |=> ($stable(bias_even) && $stable(bias_odd)));

  assert_anomaly_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    anomaly |-> (locked && count_valid));

  assert_fail_excludes_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_fail |-> !locked);
endmodule

bind tdc_cal_ctrl tdc_cal_ctrl_chk #(.NSTAGE(NSTAGE), .BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
  .bias_even(bias_even), .bias_odd(bias_odd), .count(count),
  .count_valid(count_valid), .locked(locked), .cal_fail(cal_fail),
  .anomaly(anomaly)
);

// File: tb/tdc_cal_ctrl_tb.sv
`timescale 1ns/1ps
module tdc_cal_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sample_valid = 1'b0;
  logic [19:0] stage_bits = '0;
  logic [4:0]  golden = 5'd10;
  logic [4:0]  tol = 5'd1;
  logic [7:0]  bias_even, bias_odd;
  logic [4:0]  count;
  logic        count_valid, bubble_err, locked, cal_fail, anomaly;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tdc_cal_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
    .stage_bits(stage_bits), .golden(golden), .tol(tol),
    .bias_even(bias_even), .bias_odd(bias_odd), .count(count),
    .count_valid(count_valid), .bubble_err(bubble_err), .locked(locked),
    .cal_fail(cal_fail), .anomaly(anomaly)
  );

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] therm(int n);
    logic [19:0] v = '0;
    for (int i = 0; i < 20; i++) if (i < n) v[i] = 1'b1;
    return v;
  endfunction

  function automatic int line_model(int be, int bo, int cap);
    int c = (be + bo) / 32;
    if (c > cap) c = cap;
    if (c > 20) c = 20;
    return c;
  endfunction

  task automatic sample(logic [19:0] b);
    @(negedge clk);
    stage_bits   = b;
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic model_steps(int k, int cap);
    for (int i = 0; i < k; i++)
      sample(therm(line_model(bias_even, bias_odd, cap)));
  endtask

  task automatic test_reset();
    check("R1 bias_even", bias_even, 0);
    check("R1 bias_odd", bias_odd, 0);
    check("R1 count", count, 0);
    check("R1 flags", {count_valid, bubble_err, locked, cal_fail, anomaly}, 0);
  endtask

  task automatic test_cal_pass();
    pulse_start();
    check("R4 start even", bias_even, 0);
    check("R4 start odd", bias_odd, 128);
    model_steps(1, 20);
    check("R4 first even step", bias_even, 1);
    check("R4 odd held", bias_odd, 128);
    repeat (3) @(negedge clk);
    check("R4 no sample no step", bias_even, 1);
    model_steps(191, 20);
    check("R4 even at 192", bias_even, 192);
    check("R4 not locked yet", locked, 0);
    model_steps(1, 20);
    check("R5 even kept", bias_even, 192);
    check("R5 odd restarts", bias_odd, 0);
    model_steps(128, 20);
    check("R5 odd at 128", bias_odd, 128);
    check("R5 not locked yet", locked, 0);
    model_steps(1, 20);
    check("R6 locked", locked, 1);
    check("R6 even frozen", bias_even, 192);
    check("R6 odd frozen", bias_odd, 128);
  endtask

  task automatic test_decode();
    sample(therm(20));
    check("R2 full count", count, 20);
    check("R2 valid pulse", count_valid, 1);
    check("R3 clean no bubble", bubble_err, 0);
    @(negedge clk);
    check("R2 valid drops", count_valid, 0);
    sample(20'h0);
    check("R2 zero count", count, 0);
    sample(therm(5) | 20'h00080);
    check("R3 bubble count", count, 5);
    check("R3 bubble flag", bubble_err, 1);
    sample(therm(10));
    check("R3 bubble clears", bubble_err, 0);
    check("R6 frozen after samples", {bias_even, bias_odd}, {8'd192, 8'd128});
  endtask

  task automatic test_measure();
    golden = 5'd10;
    tol    = 5'd1;
    sample(therm(10));
    check("R7 equal no anomaly", anomaly, 0);
    sample(therm(11));
    check("R7 +tol no anomaly", anomaly, 0);
    sample(therm(9));
    check("R7 -tol no anomaly", anomaly, 0);
    sample(therm(12));
    check("R7 above anomaly", anomaly, 1);
    check("R7 count with anomaly", count, 12);
    @(negedge clk);
    check("R7 anomaly one cycle", anomaly, 0);
    sample(therm(8));
    check("R7 below anomaly", anomaly, 1);
    tol = 5'd0;
    sample(therm(11));
    check("R7 zero tol anomaly", anomaly, 1);
    tol = 5'd1;
  endtask

  task automatic test_cal_fail();
    pulse_start();
    check("R8 start clears lock", locked, 0);
    model_steps(255, 9);
    check("R8 even at full", bias_even, 255);
    check("R8 no fail yet", cal_fail, 0);
    model_steps(1, 9);
    check("R8 cal_fail", cal_fail, 1);
    check("R8 not locked", locked, 0);
    check("R8 code kept", bias_even, 255);
    model_steps(3, 9);
    check("R8 sweep stopped", bias_even, 255);
    pulse_start();
    check("R8 start clears fail", cal_fail, 0);
    check("R4 restart odd mid", bias_odd, 128);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_cal_pass();
    test_decode();
    test_measure();
    test_cal_fail();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule